// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block is a register-mapped CRC accelerator on a plain 32-bit write/read bus. Software picks one of four generator polynomials (one 32-bit, three 16-bit), optionally loads a seed of all zeros or all ones, and then writes payload data. Each payload write passes through an input formatter. The formatter can swap the bytes of a word and can mirror the bits inside every byte. The formatted word or byte then goes into the running remainder in a single clock.

The remainder can be read straight back from the data address. A second address returns the same remainder with its bit order mirrored across the active width. This gives software the reflected form of the result without a loop. Control bits can be written whole, or changed one bit at a time through a set alias and a clear alias.

Top module: `crc_engine`

## Requirements
- R1: Control fields are: bit 0 seed-load request, bit 1 seed select, bit 2 enable, bits 5:4 polynomial select, bit 8 force-byte mode, bit 9 per-byte bit mirror, bits 11:10 byte order. All other bits read as 0. Offset 0x00 writes the register. Writing 1s at 0x04 sets the named bits. Writing 1s at 0x08 clears them. Byte enable 0 gates bits 7:0 and byte enable 1 gates bits 15:8. All three offsets read back the control value.
- R2: A control write that leaves bit 0 at 1 loads the remainder in that same clock: all ones if the resulting seed select is 1, all zeros if it is 0. Bit 0 always reads back 0.
- R3: Polynomial select 0 is 0x04C11DB7 (32-bit), 1 is 0x1021, 2 is 0x3D65 and 3 is 0x8005 (all 16-bit).
- R4: A data write (offset 0x10) with all four byte enables set and force-byte mode off is processed as a 32-bit word. Any other non-zero enable pattern, or any write while force-byte mode is on, is processed as one byte: the byte lane of the lowest set enable. A write with no byte enables has no effect.
- R5: With bit mirroring on, the bit order inside every input byte is reversed before the data reaches the CRC.
- R6: Byte order 0 leaves a word unchanged. Order 1 turns bytes B3 B2 B1 B0 into B2 B3 B0 B1. Order 2 turns them into B0 B1 B2 B3. Order 3 acts as order 0. Reordering applies only to word writes.
- R7: Data writes change the remainder only while the enable bit is 1.
- R8: A read at 0x10 returns the remainder. In 16-bit modes bits 31:16 read as 0.
- R9: A read at 0x20 returns the remainder with its bits mirrored across the active width (32 or 16). Bits above a 16-bit width read 0.
- R10: Reordering comes before bit mirroring. The formatted data enters the remainder most significant bit first, and a word or byte is fully absorbed in the clock of its write.
- R11: After reset the control register and the remainder are both 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte enables of the write |
| addr | input | ADDR_W (6) | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |

## Verification
The bench sweeps every combination of polynomial, byte order (including the unused code), bit mirroring, seed value and force-byte mode. It feeds each one a mix of word writes, single-lane writes and an empty-enable write. A design that reordered after mirroring, used the wrong lane or width, or fed the data least significant bit first would give a wrong remainder and a wrong mirrored read. Standard check strings over the ASCII digits anchor the polynomial constants and the seeds against published results. Further cases cover reserved bits reading zero, set/clear aliases that disturb other bits, writes while disabled moving the remainder, and stale upper bits showing in 16-bit modes.

// File: rtl/crc_pkg.sv
// crc_pkg: shared types, register offsets and pure helper functions of the
// CRC engine. Assumes a 32-bit data bus; offsets are byte addresses.
package crc_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int NPOLY  = 4;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_SET  = 8'h04;
    localparam logic [7:0] OFF_CLR  = 8'h08;
    localparam logic [7:0] OFF_DATA = 8'h10;
    localparam logic [7:0] OFF_RREV = 8'h20;

    // Stored control fields (the seed-load request is never stored).
    typedef struct packed {
        logic [1:0] order;
        logic       mirror;
        logic       force_byte;
        logic [1:0] poly;
        logic       enable;
        logic       seed_one;
    } ctrl_t;

    // Generator polynomial for each select code.
    function automatic logic [31:0] poly_value(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'h04C1_1DB7;
            2'd1:    return 32'h0000_1021;
            2'd2:    return 32'h0000_3D65;
            default: return 32'h0000_8005;
        endcase
    endfunction

    // True when the select code names the 32-bit polynomial.
    function automatic logic poly_wide(input logic [1:0] sel);
        return sel == 2'd0;
    endfunction

    // Mirror the bit order of one byte.
    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // Mirror a 32-bit value.
    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

endpackage

// File: rtl/crc_ctrl_regs.sv
// crc_ctrl_regs: holds the control fields and applies direct, set and clear
// writes lane by lane. Flags a seed load when a write leaves the request bit
// at 1. Assumes at most one of the three write strobes is high per cycle.
module crc_ctrl_regs
    import crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_direct,
    input  logic        wr_set,
    input  logic        wr_clr,
    input  logic [1:0]  lane_en,
    input  ctrl_t       wfield,
    input  logic        wseed_req,
    output ctrl_t       ctrl_q,
    output ctrl_t       ctrl_d,
    output logic        seed_load
);

    localparam int LO_W = 6;   // seed_one, enable, poly live in lane 0
    localparam int HI_W = 4;   // force_byte, mirror, order live in lane 1

    logic [LO_W-1:0] lo_q, lo_w, lo_n;
    logic [HI_W-1:0] hi_q, hi_w, hi_n;

    assign lo_q = {2'b00, ctrl_q.poly, ctrl_q.enable, ctrl_q.seed_one};
    assign lo_w = {2'b00, wfield.poly, wfield.enable, wfield.seed_one};
    assign hi_q = {ctrl_q.order, ctrl_q.mirror, ctrl_q.force_byte};
    assign hi_w = {wfield.order, wfield.mirror, wfield.force_byte};

    // Next value of the lane-0 fields under the active write flavour.
    always_comb begin
        lo_n = lo_q;
        if (lane_en[0]) begin
            if (wr_direct)   lo_n = lo_w;
            else if (wr_set) lo_n = lo_q | lo_w;
            else if (wr_clr) lo_n = lo_q & ~lo_w;
        end
    end

    // Next value of the lane-1 fields under the active write flavour.
    always_comb begin
        hi_n = hi_q;
        if (lane_en[1]) begin
            if (wr_direct)   hi_n = hi_w;
            else if (wr_set) hi_n = hi_q | hi_w;
            else if (wr_clr) hi_n = hi_q & ~hi_w;
        end
    end

    // Reassemble the next control value and decide on a seed load.
    always_comb begin
        ctrl_d            = '0;
        ctrl_d.seed_one   = lo_n[0];
        ctrl_d.enable     = lo_n[1];
        ctrl_d.poly       = lo_n[3:2];
        ctrl_d.force_byte = hi_n[0];
        ctrl_d.mirror     = hi_n[1];
        ctrl_d.order      = hi_n[3:2];
        seed_load         = lane_en[0] && wseed_req && (wr_direct || wr_set);
    end

    // Control register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/crc_input_fmt.sv
// crc_input_fmt: turns one bus write into the bit stream for the CRC. It
// picks word or byte width, reorders the bytes of a word, then mirrors each
// byte if asked. A byte result sits in bits 7:0. Purely combinational.
module crc_input_fmt
    import crc_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic              force_byte,
    input  logic [1:0]        order,
    input  logic              mirror,
    output logic [DATA_W-1:0] fmt_data,
    output logic              is_byte,
    output logic              any_lane
);

    logic [7:0]        lane   [LANES];
    logic [7:0]        picked;
    logic [DATA_W-1:0] ordered, pre_mirror, mirrored;

    // Split the bus word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane[g] = wdata[8*g +: 8];
    end

    // Choose the lane of the lowest set byte enable.
    always_comb begin
        picked = lane[0];
        for (int i = LANES - 1; i >= 0; i--) begin
            if (be[i]) picked = lane[i];
        end
    end

    // Width decision: a full word only with every enable and no forcing.
    always_comb begin
        any_lane = |be;
        is_byte  = force_byte || (be != {LANES{1'b1}});
    end

    // Byte reordering of a full word.
    always_comb begin
        case (order)
            2'd1:    ordered = {lane[2], lane[3], lane[0], lane[1]};
            2'd2:    ordered = {lane[0], lane[1], lane[2], lane[3]};
            default: ordered = wdata;
        endcase
    end

    // Stage ahead of the mirror: reordered word or the single picked byte.
    assign pre_mirror = is_byte ? {{(DATA_W-8){1'b0}}, picked} : ordered;

    // Per-byte bit mirroring after reordering.
    for (genvar g = 0; g < LANES; g++) begin : g_mirror
        assign mirrored[8*g +: 8] = rev8(pre_mirror[8*g +: 8]);
    end

    assign fmt_data = mirror ? mirrored : pre_mirror;

endmodule

// File: rtl/crc_fold.sv
// crc_fold: computes the next remainder for each polynomial in parallel and
// selects one. The data enters MSB first: 32 bits for a word, bits 7:0 for a
// byte. In 16-bit modes only the low half of the remainder takes part.
module crc_fold
    import crc_pkg::*;
(
    input  logic [DATA_W-1:0] crc_cur,
    input  logic [DATA_W-1:0] din,
    input  logic              is_byte,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] crc_next
);

    // Serial-equivalent update unrolled over the data bits.
    function automatic logic [31:0] fold_bits(input logic [31:0] c,
                                              input logic [31:0] d,
                                              input logic        byte_only,
                                              input logic        wide,
                                              input logic [31:0] poly);
        logic [31:0] r;
        logic        fb;
        r = wide ? c : {16'h0000, c[15:0]};
        for (int i = 31; i >= 0; i--) begin
            if (!byte_only || i < 8) begin
                fb = (wide ? r[31] : r[15]) ^ d[i];
                r  = {r[30:0], 1'b0};
                if (!wide) r[31:16] = 16'h0000;
                if (fb) r = r ^ poly;
            end
        end
        return r;
    endfunction

    logic [DATA_W-1:0] cand [NPOLY];

    // One update network per polynomial.
    for (genvar g = 0; g < NPOLY; g++) begin : g_poly
        localparam logic [1:0]  SEL_G  = 2'(g);
        localparam logic [31:0] POLY_G = poly_value(SEL_G);
        localparam logic        WIDE_G = poly_wide(SEL_G);
        assign cand[g] = fold_bits(crc_cur, din, is_byte, WIDE_G, POLY_G);
    end

    assign crc_next = cand[sel];

endmodule

// File: rtl/crc_engine.sv
// crc_engine: top level. Decodes the bus, holds the remainder, and drives the
// read mux. Assumes a seed load and a data write never share a cycle (they
// use different offsets). Reads are combinational from addr.
module crc_engine
    import crc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_RREV = ADDR_W'(OFF_RREV);

    ctrl_t             ctrl_q, ctrl_d, wfield;
    logic              seed_load;
    logic              wr_direct, wr_set, wr_clr, wr_data;
    logic [DATA_W-1:0] fmt_data, crc_q, crc_next, crc_view;
    logic              is_byte, any_lane;

    // Address decode of the write strobe.
    always_comb begin
        wr_direct = wr_en && (addr == A_CTRL);
        wr_set    = wr_en && (addr == A_SET);
        wr_clr    = wr_en && (addr == A_CLR);
        wr_data   = wr_en && (addr == A_DATA);
    end

    // Map the write data bits onto control fields.
    always_comb begin
        wfield            = '0;
        wfield.seed_one   = wdata[1];
        wfield.enable     = wdata[2];
        wfield.poly       = wdata[5:4];
        wfield.force_byte = wdata[8];
        wfield.mirror     = wdata[9];
        wfield.order      = wdata[11:10];
    end

    crc_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_direct (wr_direct),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .lane_en   (wr_be[1:0]),
        .wfield    (wfield),
        .wseed_req (wdata[0]),
        .ctrl_q    (ctrl_q),
        .ctrl_d    (ctrl_d),
        .seed_load (seed_load)
    );

    crc_input_fmt u_fmt (
        .wdata      (wdata),
        .be         (wr_be),
        .force_byte (ctrl_q.force_byte),
        .order      (ctrl_q.order),
        .mirror     (ctrl_q.mirror),
        .fmt_data   (fmt_data),
        .is_byte    (is_byte),
        .any_lane   (any_lane)
    );

    crc_fold u_fold (
        .crc_cur  (crc_q),
        .din      (fmt_data),
        .is_byte  (is_byte),
        .sel      (ctrl_q.poly),
        .crc_next (crc_next)
    );

    // Remainder register: seed load, gated data update, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= '0;
        else if (seed_load)
            crc_q <= ctrl_d.seed_one ? {DATA_W{1'b1}} : '0;
        else if (wr_data && any_lane && ctrl_q.enable)
            crc_q <= crc_next;
    end

    // Remainder limited to the active polynomial width.
    assign crc_view = poly_wide(ctrl_q.poly) ? crc_q : {16'h0000, crc_q[15:0]};

    // Read mux over the mapped offsets.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL || addr == A_SET || addr == A_CLR) begin
            rdata[1]     = ctrl_q.seed_one;
            rdata[2]     = ctrl_q.enable;
            rdata[5:4]   = ctrl_q.poly;
            rdata[8]     = ctrl_q.force_byte;
            rdata[9]     = ctrl_q.mirror;
            rdata[11:10] = ctrl_q.order;
        end else if (addr == A_DATA) begin
            rdata = crc_view;
        end else if (addr == A_RREV) begin
            rdata = poly_wide(ctrl_q.poly) ? rev32(crc_q)
                                           : {16'h0000, rev32(crc_view)[31:16]};
        end
    end

endmodule

// File: rtl/crc_engine_chk.sv
// crc_engine_chk: temporal checks on the CRC engine, attached by bind.
module crc_engine_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              be0,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        seed_bits,
    input logic [31:0]       rdata,
    input logic [31:0]       crc_q,
    input logic              ctrl_en,
    input logic [1:0]        poly_sel
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h10);

    assert_seed_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && be0 && seed_bits == 2'b11) |=> crc_q == 32'hFFFF_FFFF);

    assert_seed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && be0 && seed_bits == 2'b01) |=> crc_q == 32'h0);

    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA && !ctrl_en) |=> $stable(crc_q));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_DATA && poly_sel != 2'd0) |-> rdata[31:16] == 16'h0);

    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> crc_q == 32'h0);

endmodule

bind crc_engine crc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .be0       (wr_be[0]),
    .addr      (addr),
    .seed_bits (wdata[1:0]),
    .rdata     (rdata),
    .crc_q     (crc_q),
    .ctrl_en   (ctrl_q.enable),
    .poly_sel  (ctrl_q.poly)
);

// File: tb/crc_engine_test.sv
module crc_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [5:0]  addr = 6'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [31:0] m_crc;
    logic [1:0]  m_poly;
    logic        m_mir, m_fb;
    logic [1:0]  m_ord;

    crc_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_be = be; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // One MSB-first bit step of the remainder for the selected polynomial.
    function automatic logic [31:0] step(input logic [31:0] c, input logic b, input logic [1:0] p);
        logic [31:0] g;
        logic [31:0] r;
        g = (p == 0) ? 32'h04C11DB7 : (p == 1) ? 32'h1021 : (p == 2) ? 32'h3D65 : 32'h8005;
        if (p == 0) begin
            r = {c[30:0], 1'b0};
            return (c[31] ^ b) ? r ^ g : r;
        end
        r = {16'h0, c[14:0], 1'b0};
        return (c[15] ^ b) ? r ^ g : r;
    endfunction

    function automatic logic [7:0] mir8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    // Model of one data write per the requirements.
    task automatic model_write(input logic [3:0] be, input logic [31:0] d);
        logic [7:0] bs [4];
        logic [7:0] seq [4];
        int n;
        for (int i = 0; i < 4; i++) bs[i] = d[8*i +: 8];
        if (be == 0) return;
        if (!m_fb && be == 4'hF) begin
            n = 4;
            // seq[0] is the most significant byte of the reordered word
            if (m_ord == 1)      begin seq[0]=bs[2]; seq[1]=bs[3]; seq[2]=bs[0]; seq[3]=bs[1]; end
            else if (m_ord == 2) begin seq[0]=bs[0]; seq[1]=bs[1]; seq[2]=bs[2]; seq[3]=bs[3]; end
            else                 begin seq[0]=bs[3]; seq[1]=bs[2]; seq[2]=bs[1]; seq[3]=bs[0]; end
        end else begin
            n = 1;
            seq[0] = be[0] ? bs[0] : be[1] ? bs[1] : be[2] ? bs[2] : bs[3];
        end
        if (m_poly != 0) m_crc[31:16] = 16'h0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = m_mir ? mir8(seq[k]) : seq[k];
            for (int j = 7; j >= 0; j--) m_crc = step(m_crc, b[j], m_poly);
        end
    endtask

    function automatic logic [31:0] exp_data();
        return (m_poly == 0) ? m_crc : {16'h0, m_crc[15:0]};
    endfunction

    function automatic logic [31:0] exp_rev();
        logic [31:0] r = 0;
        if (m_poly == 0) for (int i = 0; i < 32; i++) r[i] = m_crc[31-i];
        else             for (int i = 0; i < 16; i++) r[i] = m_crc[15-i];
        return r;
    endfunction

    // Configure: seed load, enable, with the given fields.
    task automatic configure(input logic [1:0] p, input logic [1:0] o, input logic mir,
                             input logic fb, input logic seed);
        bus_write(6'h00, 4'b0011, {20'h0, o, mir, fb, 2'b00, p, 1'b0, 1'b1, seed, 1'b1});
        m_poly = p; m_ord = o; m_mir = mir; m_fb = fb;
        m_crc = seed ? 32'hFFFF_FFFF : 32'h0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rd;
        logic [31:0] words [3];
        words[0] = 32'h1234_5678; words[1] = 32'h80F0_0C01; words[2] = 32'hDEAD_BEEF;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state
        bus_read(6'h00, rd); check("R11 ctrl after reset", rd, 32'h0);
        bus_read(6'h10, rd); check("R11 crc after reset", rd, 32'h0);
        bus_read(6'h14, rd); check("R11 unmapped read", rd, 32'h0);

        // R1/R2: reserved bits, seed-load readback, aliases
        bus_write(6'h00, 4'hF, 32'hFFFF_FFFF);
        bus_read(6'h00, rd); check("R1 R2 ctrl readback", rd, 32'h0000_0F36);
        bus_read(6'h10, rd); check("R2 seed ones 16-bit", rd, 32'h0000_FFFF);
        bus_write(6'h08, 4'hF, 32'h0000_0204);
        bus_read(6'h04, rd); check("R1 clear alias", rd, 32'h0000_0D32);
        bus_write(6'h04, 4'h1, 32'h0000_0104);
        bus_read(6'h08, rd); check("R1 set alias lane gating", rd, 32'h0000_0D36);
        bus_write(6'h00, 4'h1, 32'h0000_0001);
        bus_read(6'h10, rd); check("R2 seed zeros", rd, 32'h0);
        bus_read(6'h00, rd); check("R1 direct lane0 write", rd, 32'h0000_0D00);

        // R3/R10: standard check strings over "123456789"
        configure(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++) bus_write(6'h10, 4'h1, 32'h31 + i);
        bus_read(6'h10, rd); check("R3 R10 32-bit check value", rd, 32'h0376_E6E7);
        bus_read(6'h20, rd); check("R9 32-bit mirrored", rd, 32'hE767_6EC0);
        configure(2'd1, 2'd0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++) bus_write(6'h10, 4'h2, (32'h31 + i) << 8);
        bus_read(6'h10, rd); check("R3 R4 0x1021 check value", rd, 32'h0000_29B1);
        configure(2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) bus_write(6'h10, 4'h1, 32'h31 + i);
        bus_read(6'h10, rd); check("R3 0x8005 check value", rd, 32'h0000_FEE8);

        // R7: disabled writes leave the remainder
        bus_write(6'h08, 4'h1, 32'h0000_0004);
        bus_write(6'h10, 4'hF, 32'hCAFE_F00D);
        bus_read(6'h10, rd); check("R7 disabled write ignored", rd, 32'h0000_FEE8);

        // R4-R10: sweep of every configuration
        for (int p = 0; p < 4; p++)
        for (int o = 0; o < 4; o++)
        for (int mi = 0; mi < 2; mi++)
        for (int fb = 0; fb < 2; fb++)
        for (int sd = 0; sd < 2; sd++) begin
            configure(2'(p), 2'(o), 1'(mi), 1'(fb), 1'(sd));
            for (int w = 0; w < 3; w++) begin
                bus_write(6'h10, 4'hF, words[w] ^ (p * 32'h0101_0101));
                model_write(4'hF, words[w] ^ (p * 32'h0101_0101));
            end
            bus_write(6'h10, 4'b0100, 32'h00A5_0000); model_write(4'b0100, 32'h00A5_0000);
            bus_write(6'h10, 4'b0000, 32'hFFFF_FFFF); model_write(4'b0000, 32'hFFFF_FFFF);
            bus_write(6'h10, 4'b1010, 32'h3C00_9600); model_write(4'b1010, 32'h3C00_9600);
            bus_read(6'h10, rd); check("R4 R5 R6 R8 R10 sweep data", rd, exp_data());
            bus_read(6'h20, rd); check("R9 sweep mirrored", rd, exp_rev());
        end

        // R8: stale upper bits hidden after switching to a 16-bit polynomial
        configure(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        bus_write(6'h04, 4'h1, 32'h0000_0010);
        bus_read(6'h10, rd); check("R8 upper half hidden", rd, 32'h0000_FFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule